// File: doc/BRIEF.md
# PRBS7 Lane Test Pattern Source

This block sits in front of a multi-lane serializer and turns the parallel data path into an at-speed link self test on request. A raw test-request input is qualified by a run-length filter: it must hold a new level for four consecutive clock edges before the block changes mode. Requests of three cycles or fewer in either direction have no effect.

In pass mode the 32-bit payload word is split into four 8-bit lane symbols and forwarded unchanged. In test mode the payload is disregarded. Each lane then emits symbols from its own 7-bit maximal-length generator (feedback x^7 + x^6 + 1). Each generator steps eight bit positions per clock, so every clock produces one fresh 8-bit symbol per lane, and the symbol stream repeats every 127 clocks. The generators are held at the all-ones state whenever the block is in pass mode, so every test run starts from the same point. Serialization, clocking and line drivers belong to the surrounding logic.

Top module: `prbs_tx_top`

## Requirements
- R1: In test mode each lane symbol is built from the sequence of the recurrence x^7 + x^6 + 1. The generator state is never all zeros. The symbol stream of a lane repeats with a period of exactly 127 clocks and never contains an all-zero symbol.
- R2: Test mode turns on after the rising clock edge that samples the request high for the fourth consecutive time. A high request lasting three or fewer edges leaves the block in pass mode.
- R3: Test mode turns off after the fourth consecutive edge that samples the request low. Low dips of three or fewer edges leave test mode, and the running sequence, undisturbed.
- R4: While test mode is active, the lane outputs do not depend on the payload input.
- R5: In pass mode, lane n (n = 0..3) outputs payload bits [8n+7:8n] combinationally, and the test-active output is low.
- R6: On every entry into test mode, the generator starts from the all-ones state. The first symbol therefore holds the first eight sequence bits produced from all ones.
- R7: Symbol bit 7 is the earliest sequence bit; the sequence bit is the generator's most significant state bit. Each lane has its own generator, which advances eight steps per clock while test mode is active. All lanes show the same symbol in the same cycle.
- R8: While reset is asserted and right after it, the block is in pass mode and the test-active output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also paces the generators |
| rst | input | 1 | Synchronous active-high reset |
| test_req_i | input | 1 | Raw test-mode request level |
| payload_i | input | 32 | Parallel user data word |
| test_active_o | output | 1 | High while test mode is in force |
| lane_sym_o | output | 32 | Four 8-bit lane symbols, lane n at bits [8n+7:8n] |

## Verification
On every cycle, the embedded assertions check four things. A mode change is always preceded by a qualifying run of request samples. A generator state is never all zeros. The generator sits at all ones in the first test cycle. It moves every cycle while test mode lasts. Only the bench scenarios can show that the symbols match an independently computed sequence, that the stream period is 127, that the payload is really ignored under random data, and that short pulses and dips in both modes leave the outputs untouched.

// File: rtl/prbs_tx_pkg.sv
package prbs_tx_pkg;

    localparam int LFSR_W = 7;

    typedef logic [LFSR_W-1:0] lfsr_t;

    localparam lfsr_t LFSR_SEED = '1;

    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_TEST = 1'b1
    } tx_mode_e;

    // One step of the x^7 + x^6 + 1 recurrence; the emitted bit is the MSB.
    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    endfunction

endpackage

// File: rtl/prbs_tx_en_filter.sv
module prbs_tx_en_filter
    import prbs_tx_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic test_o
);

    localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    tx_mode_e         mode_q;
    logic [CNT_W-1:0] run_q;
    logic             differs;

    assign differs = req_i != (mode_q == MODE_TEST);
    assign test_o  = (mode_q == MODE_TEST);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PASS;
            run_q  <= '0;
        end else if (!differs) begin
            run_q <= '0;
        end else if (run_q == CNT_LAST) begin
            mode_q <= (mode_q == MODE_TEST) ? MODE_PASS : MODE_TEST;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // Independent run trackers used only by the checks below.
    localparam int CHK_W = $clog2(RUN_LEN + 1) + 1;
    localparam logic [CHK_W-1:0] CHK_MAX = CHK_W'(RUN_LEN);

    logic [CHK_W-1:0] hi_run_q, lo_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= req_i ? ((hi_run_q == CHK_MAX) ? hi_run_q : hi_run_q + 1'b1) : '0;
            lo_run_q <= req_i ? '0 : ((lo_run_q == CHK_MAX) ? lo_run_q : lo_run_q + 1'b1);
        end
    end

    assert_enter_after_run_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(test_o) |-> (hi_run_q >= CHK_MAX));

    assert_leave_after_run_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(test_o) |-> (lo_run_q >= CHK_MAX));

endmodule

// File: rtl/prbs_tx_lane_gen.sv
module prbs_tx_lane_gen
    import prbs_tx_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    output logic [SYM_W-1:0] sym_o
);

    lfsr_t state_q;
    lfsr_t chain [SYM_W+1];

    assign chain[0] = state_q;

    for (genvar k = 0; k < SYM_W; k++) begin : g_step
        assign chain[k+1]        = lfsr_step(chain[k]);
        assign sym_o[SYM_W-1-k]  = chain[k][LFSR_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            state_q <= LFSR_SEED;
        end else begin
            state_q <= chain[SYM_W];
        end
    end

    assert_state_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    assert_seed_on_entry_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(active_i) |-> (state_q == LFSR_SEED));

    assert_advance_each_clock_R7: assert property (@(posedge clk) disable iff (rst)
        (active_i && $past(active_i)) |-> (state_q != $past(state_q)));

endmodule

// File: rtl/prbs_tx_lane_mux.sv
module prbs_tx_lane_mux #(
    parameter int LANES = 4,
    parameter int SYM_W = 8
) (
    input  logic                   test_i,
    input  logic [LANES*SYM_W-1:0] payload_i,
    input  logic [LANES*SYM_W-1:0] gen_i,
    output logic [LANES*SYM_W-1:0] lane_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_o[l*SYM_W +: SYM_W] = test_i ? gen_i[l*SYM_W +: SYM_W]
                                                 : payload_i[l*SYM_W +: SYM_W];
    end

endmodule

// File: rtl/prbs_tx_top.sv
module prbs_tx_top #(
    parameter int LANES     = 4,
    parameter int PAYLOAD_W = 32,
    parameter int RUN_LEN   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 test_req_i,
    input  logic [PAYLOAD_W-1:0] payload_i,
    output logic                 test_active_o,
    output logic [PAYLOAD_W-1:0] lane_sym_o
);

    localparam int SYM_W = PAYLOAD_W / LANES;

    logic                 test_mode;
    logic [PAYLOAD_W-1:0] gen_sym;

    prbs_tx_en_filter #(.RUN_LEN(RUN_LEN)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .req_i  (test_req_i),
        .test_o (test_mode)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_gen
        prbs_tx_lane_gen #(.SYM_W(SYM_W)) u_gen (
            .clk      (clk),
            .rst      (rst),
            .active_i (test_mode),
            .sym_o    (gen_sym[l*SYM_W +: SYM_W])
        );
    end

    prbs_tx_lane_mux #(.LANES(LANES), .SYM_W(SYM_W)) u_mux (
        .test_i    (test_mode),
        .payload_i (payload_i),
        .gen_i     (gen_sym),
        .lane_o    (lane_sym_o)
    );

    assign test_active_o = test_mode;

endmodule

// File: tb/prbs_tx_top_test.sv
module prbs_tx_top_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        test_req;
    logic [31:0] payload;
    logic        test_active;
    logic [31:0] lane_sym;

    int checks = 0;
    int fails  = 0;

    logic       exp_active = 1'b0;
    int         run        = 0;
    logic [6:0] mstate     = 7'h7F;
    bit         entry_flag = 1'b0;
    bit         log_on     = 1'b0;
    int         log_n      = 0;
    logic [7:0] sym_log [0:299];
    string      cur_tag    = "R2";

    always #(PERIOD/2) clk = ~clk;

    prbs_tx_top uut (
        .clk           (clk),
        .rst           (rst),
        .test_req_i    (test_req),
        .payload_i     (payload),
        .test_active_o (test_active),
        .lane_sym_o    (lane_sym)
    );

    function automatic logic [6:0] b_step(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    function automatic logic [7:0] b_sym(input logic [6:0] s);
        logic [7:0] r;
        logic [6:0] t = s;
        for (int k = 0; k < 8; k++) begin
            r[7-k] = t[6];
            t = b_step(t);
        end
        return r;
    endfunction

    function automatic logic [6:0] b_adv(input logic [6:0] s);
        logic [6:0] t = s;
        for (int k = 0; k < 8; k++) t = b_step(t);
        return t;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic req_v);
        logic [7:0] es;
        @(negedge clk);
        test_req = req_v;
        payload  = $urandom;
        #1;
        chk(test_active == exp_active, cur_tag, 32'(test_active), 32'(exp_active));
        if (exp_active) begin
            es = b_sym(mstate);
            for (int l = 0; l < 4; l++)
                chk(lane_sym[l*8 +: 8] == es, (l == 0) ? "R4" : "R7", 32'(lane_sym[l*8 +: 8]), 32'(es));
            chk(lane_sym[7:0] != 8'h00, "R1", 32'(lane_sym[7:0]), 32'h1);
            if (entry_flag) begin
                chk(lane_sym[7:0] == b_sym(7'h7F), "R6", 32'(lane_sym[7:0]), 32'(b_sym(7'h7F)));
                entry_flag = 1'b0;
            end
            if (log_on && log_n < 300) begin
                sym_log[log_n] = lane_sym[7:0];
                log_n++;
            end
        end else begin
            chk(lane_sym == payload, "R5", lane_sym, payload);
        end
        @(posedge clk);
        // reference model update for this edge
        mstate = exp_active ? b_adv(mstate) : 7'h7F;
        if (req_v == exp_active) run = 0;
        else if (run == 3) begin
            exp_active = ~exp_active;
            run = 0;
            if (exp_active) entry_flag = 1'b1;
        end else run++;
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) cyc(v);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1;
        test_req = 1'b1;
        payload = 32'hA5A5_0F0F;
        @(posedge clk);
        @(negedge clk);
        // R8: reset holds pass mode even with the request high
        chk(test_active == 1'b0, "R8", 32'(test_active), 32'h0);
        chk(lane_sym == payload, "R8", lane_sym, payload);
        @(posedge clk);
        @(negedge clk);
        test_req = 1'b0;
        rst = 1'b0;
        chk(test_active == 1'b0, "R8", 32'(test_active), 32'h0);

        // R5: random payload pass-through
        cur_tag = "R5";
        hold(1'b0, 20);

        // R2: pulses of 1..3 edges rejected
        cur_tag = "R2";
        hold(1'b1, 1); hold(1'b0, 3);
        hold(1'b1, 2); hold(1'b0, 3);
        hold(1'b1, 3); hold(1'b0, 3);
        // R2: four edges enters test mode
        hold(1'b1, 4);
        chk(exp_active == 1'b1, "R2", 32'(exp_active), 32'h1);

        // R1, R4, R7: steady test run with logging
        log_on = 1'b1;
        hold(1'b1, 300);
        log_on = 1'b0;
        chk(log_n == 300, "R1", 32'(log_n), 32'd300);
        for (int k = 0; k + 127 < log_n; k++)
            chk(sym_log[k+127] == sym_log[k], "R1", 32'(sym_log[k+127]), 32'(sym_log[k]));
        for (int p = 1; p < 127; p++)
            chk(sym_log[p] != sym_log[0] || sym_log[p+1] != sym_log[1], "R1", 32'(p), 32'd127);

        // R3: short low dips ignored, four lows leave
        cur_tag = "R3";
        hold(1'b0, 1); hold(1'b1, 2);
        hold(1'b0, 2); hold(1'b1, 2);
        hold(1'b0, 3); hold(1'b1, 1);
        hold(1'b0, 4);
        chk(exp_active == 1'b0, "R3", 32'(exp_active), 32'h0);
        hold(1'b0, 10);

        // R6: re-entry restarts from all ones
        cur_tag = "R6";
        hold(1'b1, 4);
        hold(1'b1, 5);
        hold(1'b0, 4);
        hold(1'b1, 4);
        hold(1'b1, 2);

        // random request runs, both directions
        cur_tag = "R2";
        for (int r = 0; r < 120; r++) begin
            hold(1'($urandom_range(0, 1)), int'($urandom_range(1, 6)));
        end
        hold(1'b0, 4);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule